// File: doc/BRIEF.md
# I2C Byte-Write Memory Target

This block is an I2C target that only takes writes. A controller addresses it with a device-select byte and then sends a 17-bit byte address. Any number of data bytes may follow. Each accepted data byte leaves the block on a one-cycle memory write port, so the 128K x 8 array can sit outside the block as registers or inferred RAM. After each data byte the address advances by one, and it wraps at the top of the space. The transfer runs until the controller ends it with a STOP.

The select byte has the following bit layout, from bit 7 down to bit 0:

- The fixed pattern 1010.
- The level of strap pin A2.
- The level of strap pin A1.
- Bit 16 of the byte address.
- The direction bit.

The next two bytes carry address bits 15:8 and then bits 7:0. A controller that opens with a high-speed master code gets no acknowledge. The target then waits for the repeated START that follows and handles it as a fresh START.

Both bus lines pass through a synchroniser. START and STOP are found as SDA edges while SCL is high. SDA is open-drain: the block only ever asks for the pad to be pulled low.

Top module: `i2c_wr_target`

## Requirements
- R1: A select byte is acknowledged when bits 7:4 are 1010, bit 3 equals strapA2, bit 2 equals strapA1 and bit 0 is 0 (write). Bit 1 is taken as address bit 16.
- R2: A select byte that fails the R1 match on the fixed pattern or on a strap bit gets no acknowledge. Every later byte up to the next START also gets no acknowledge and causes no write.
- R3: A select byte whose direction bit (bit 0) is 1 gets no acknowledge and causes no write.
- R4: After a matching select byte, the next byte is acknowledged and loads address bits 15:8. The byte after that is acknowledged and loads address bits 7:0.
- R5: Each complete data byte is acknowledged and gives exactly one memWe pulse, with memAddr at the current address and memData at the received byte (MSB first on the wire).
- R6: After each written byte the address goes up by one, and it wraps from 0x1FFFF to 0x00000.
- R7: A master code of the form 0000_1xxx gets no acknowledge. A repeated START after it begins a normal select-byte sequence.
- R8: A START or STOP in the middle of a byte abandons that byte. A partial data byte is never written, and a repeated START goes back to select-byte decoding.
- R9: sdaPullLow is asserted only from the SCL falling edge that ends bit 0 of an accepted byte until the next SCL falling edge. It is never asserted while data bits are being received.
- R10: During reset, sdaPullLow and memWe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level at the pad |
| sdaIn | input | 1 | SDA level at the pad |
| sdaPullLow | output | 1 | Pad pulls SDA low when 1 |
| strapA2 | input | 1 | Strap matched against select bit 3 |
| strapA1 | input | 1 | Strap matched against select bit 2 |
| memWe | output | 1 | One-cycle write strobe |
| memAddr | output | 17 | Write byte address |
| memData | output | 8 | Write data |

## Verification
The hardest cases to reach are the aborted ones: a STOP or repeated START that lands a few bits into a data byte, after the address has already been loaded. The bench reaches them with a partial-byte task that clocks only some of the bits and then issues the bus condition directly. It then checks the write log for the missing entry. The address wrap is reached by a burst that starts two bytes below the top of the space. All 128 write-direction select codes are swept against fixed straps, so every mismatch path is covered.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK} busSt_t;
  typedef enum logic [1:0] {PH_SEL, PH_ADDRH, PH_ADDRL, PH_DATA} phase_t;

  typedef struct packed {
    logic shiftEn;
    logic cntClr;
    logic ldTop;
    logic ldHi;
    logic ldLo;
    logic wrByte;
  } dpStrobe_t;
endpackage

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int TOP_W       = 1,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = 2 * BYTE_W + TOP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic              byteFull,
  output logic [BYTE_W-1:0] rxByte,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memData
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow  = sclSync[SYNC_STAGES-1];
  assign sdaNow  = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (strb.cntClr) begin
      bitCnt <= '0;
    end else if (strb.shiftEn) begin
      bitCnt <= bitCnt + CNT_W'(1);
      rxByte <= {rxByte[BYTE_W-2:0], sdaNow};
    end
  end

  assign byteFull = (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= 1'b0;
      if (strb.ldTop) addrQ[ADDR_W-1 -: TOP_W]   <= rxByte[TOP_W:1];
      if (strb.ldHi)  addrQ[2*BYTE_W-1 -: BYTE_W] <= rxByte;
      if (strb.ldLo)  addrQ[BYTE_W-1:0]           <= rxByte;
      if (strb.wrByte) begin
        memWe   <= 1'b1;
        memAddr <= addrQ;
        memData <= rxByte;
        addrQ   <= addrQ + ADDR_W'(1);
      end
    end
  end

  // R6: pointer has moved one past the written location, wrapping at the top
  a_r6_addr_advance: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> addrQ == memAddr + ADDR_W'(1));

  // R5: a byte produces a single-cycle write strobe
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int          BYTE_W     = 8,
  parameter logic [3:0]  SEL_PREFIX = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              byteFull,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              strapA2,
  input  logic              strapA1,
  output dpStrobe_t         strb,
  output logic              sdaPullLow
);
  busSt_t state, stateNx;
  phase_t phase, phaseNx;
  logic   pullNx, selMatch;

  // Master codes (0000_1xxx) fail this match and fall through to idle,
  // so the following repeated START is handled as a fresh START.
  assign selMatch = (rxByte[BYTE_W-1 -: 4] == SEL_PREFIX) &&
                    (rxByte[3] == strapA2) && (rxByte[2] == strapA1) &&
                    !rxByte[0];

  always_comb begin
    strb    = '0;
    stateNx = state;
    phaseNx = phase;
    pullNx  = sdaPullLow;
    if (startEv) begin
      stateNx     = ST_RX;
      phaseNx     = PH_SEL;
      strb.cntClr = 1'b1;
      pullNx      = 1'b0;
    end else if (stopEv) begin
      stateNx = ST_IDLE;
      pullNx  = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && !byteFull) begin
            strb.shiftEn = 1'b1;
          end else if (sclFall && byteFull) begin
            stateNx = ST_ACK;
            pullNx  = 1'b1;
            unique case (phase)
              PH_SEL: begin
                if (selMatch) begin
                  strb.ldTop = 1'b1;
                  phaseNx    = PH_ADDRH;
                end else begin
                  stateNx = ST_IDLE;
                  pullNx  = 1'b0;
                end
              end
              PH_ADDRH: begin strb.ldHi = 1'b1; phaseNx = PH_ADDRL; end
              PH_ADDRL: begin strb.ldLo = 1'b1; phaseNx = PH_DATA;  end
              PH_DATA:  strb.wrByte = 1'b1;
              default:  ;
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            stateNx     = ST_RX;
            pullNx      = 1'b0;
            strb.cntClr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= PH_SEL;
      sdaPullLow <= 1'b0;
    end else begin
      state      <= stateNx;
      phase      <= phaseNx;
      sdaPullLow <= pullNx;
    end
  end

  // R9: acknowledge begins only on an SCL falling edge
  a_r9_ack_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> $past(sclFall));

  // R9: acknowledge ends on a falling edge or a bus condition
  a_r9_release_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> $past(sclFall || startEv || stopEv));

  // R5: every written byte is acknowledged
  a_r5_write_acked: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrByte |=> sdaPullLow);

  // R8: STOP releases the line and parks the target
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (!sdaPullLow && state == ST_IDLE));
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2cw_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int TOP_W       = 1,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = 2 * BYTE_W + TOP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic              strapA2,
  input  logic              strapA1,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memData
);
  dpStrobe_t         strb;
  logic              sclRise, sclFall, startEv, stopEv, byteFull;
  logic [BYTE_W-1:0] rxByte;

  i2cw_datapath #(
    .BYTE_W(BYTE_W), .TOP_W(TOP_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .byteFull(byteFull), .rxByte(rxByte),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  i2cw_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .byteFull(byteFull), .rxByte(rxByte),
    .strapA2(strapA2), .strapA1(strapA1), .strb(strb), .sdaPullLow(sdaPullLow)
  );
endmodule

// File: tb/i2c_wr_target_bench.sv
module i2c_wr_target_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic strapA2 = 1'b1, strapA1 = 1'b0;
  logic sdaLine, sdaPullLow, memWe;
  logic [16:0] memAddr;
  logic [7:0]  memData;

  int checks = 0, failures = 0;
  bit finished = 0;
  int wN = 0;
  logic [16:0] wA [0:255];
  logic [7:0]  wD [0:255];

  always #4 clk = ~clk;
  assign sdaLine = mSda & ~sdaPullLow;

  i2c_wr_target u_i2c_wr_target (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .strapA2(strapA2), .strapA1(strapA1),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  always @(negedge clk) begin
    if (memWe && wN < 256) begin
      wA[wN] = memAddr;
      wD[wN] = memData;
      wN++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1; mScl = 1; tick(Q);
    mSda = 0; tick(Q);
    mScl = 0; tick(Q);
  endtask

  task automatic busRepStart();
    mSda = 1; tick(Q);
    mScl = 1; tick(Q);
    mSda = 0; tick(Q);
    mScl = 0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 0; tick(Q);
    mScl = 1; tick(Q);
    mSda = 1; tick(Q);
  endtask

  task automatic sendPartial(input logic [7:0] b, input int n, output bit drv);
    drv = 0;
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; tick(Q);
      mScl = 1; tick(Q / 2);
      if (sdaPullLow) drv = 1;
      tick(Q - Q / 2);
      mScl = 0;
    end
  endtask

  task automatic xfer(input logic [7:0] b, input bit expAck, input string req);
    bit drv, ack, rel;
    sendPartial(b, 8, drv);
    mSda = 1; tick(Q);
    mScl = 1; tick(Q / 2);
    ack = !sdaLine;
    tick(Q - Q / 2);
    mScl = 0; tick(Q);
    rel = sdaPullLow;
    chk(ack == expAck, req, ack, expAck);
    chk(!drv && !rel, "R9", {drv, rel}, 0);
  endtask

  function automatic logic [7:0] selByte(input logic a2, input logic a1, input logic a16);
    return {4'b1010, a2, a1, a16, 1'b0};
  endfunction

  task automatic writeBurst(input logic [16:0] base, input int n, input int seed, input string req);
    xfer(selByte(strapA2, strapA1, base[16]), 1, "R1");
    xfer(base[15:8], 1, "R4");
    xfer(base[7:0], 1, "R4");
    for (int i = 0; i < n; i++) xfer(8'(i * 37 + seed), 1, req);
  endtask

  task automatic checkBurst(input int first, input logic [16:0] base, input int n, input int seed, input string req);
    chk(wN == first + n, req, wN - first, n);
    for (int i = 0; i < n; i++) begin
      logic [16:0] ea = 17'(base + 17'(i));
      logic [7:0]  ed = 8'(i * 37 + seed);
      chk(wA[first+i] == ea, req, wA[first+i], ea);
      chk(wD[first+i] == ed, req, wD[first+i], ed);
    end
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n0;
    bit drv;
    tick(5);
    // R10: reset state
    chk(sdaPullLow == 0, "R10", sdaPullLow, 0);
    chk(memWe == 0, "R10", memWe, 0);
    rstN = 1;
    tick(5);

    // R1/R2: sweep every write-direction select code with straps A2=1, A1=0
    for (int s = 0; s < 128; s++) begin
      logic [7:0] b = {7'(s), 1'b0};
      bit exp = (b[7:4] == 4'b1010) && b[3] && !b[2];
      busStart();
      xfer(b, exp, exp ? "R1" : "R2");
      busStop();
    end
    chk(wN == 0, "R2", wN, 0);

    // R2: bus ignored after mismatched select
    busStart();
    xfer(8'hB0, 0, "R2");
    xfer(8'h00, 0, "R2");
    xfer(8'h10, 0, "R2");
    xfer(8'h55, 0, "R2");
    busStop();
    chk(wN == 0, "R2", wN, 0);

    // R3: read direction refused
    busStart();
    xfer(8'hA9, 0, "R3");
    xfer(8'h00, 0, "R3");
    xfer(8'h00, 0, "R3");
    xfer(8'h3C, 0, "R3");
    busStop();
    chk(wN == 0, "R3", wN, 0);

    // R1: each strap setting, matching vs swapped straps
    for (int s = 0; s < 4; s++) begin
      strapA2 = s[1]; strapA1 = s[0];
      busStart(); xfer(selByte(s[1], s[0], 1'b0), 1, "R1"); busStop();
      busStart(); xfer(selByte(!s[1], s[0], 1'b0), 0, "R1"); busStop();
      busStart(); xfer(selByte(s[1], !s[0], 1'b1), 0, "R1"); busStop();
    end
    strapA2 = 1; strapA1 = 0;

    // R4/R5: single-byte write
    n0 = wN;
    busStart(); writeBurst(17'h0ABCD, 1, 8'h5A, "R5"); busStop();
    checkBurst(n0, 17'h0ABCD, 1, 8'h5A, "R5");

    // R6: burst across the top of the address space
    n0 = wN;
    busStart(); writeBurst(17'h1FFFE, 4, 3, "R6"); busStop();
    checkBurst(n0, 17'h1FFFE, 4, 3, "R6");

    // R5/R6: longer burst
    n0 = wN;
    busStart(); writeBurst(17'h00100, 20, 11, "R5"); busStop();
    checkBurst(n0, 17'h00100, 20, 11, "R6");

    // R7: all master codes refused, then Sr opens a write
    for (int m = 8; m < 16; m++) begin
      busStart(); xfer(8'(m), 0, "R7"); busStop();
    end
    n0 = wN;
    busStart();
    xfer(8'h0D, 0, "R7");
    busRepStart();
    writeBurst(17'h11234, 2, 8'hC3, "R7");
    busStop();
    checkBurst(n0, 17'h11234, 2, 8'hC3, "R7");

    // R8: STOP after four bits of a data byte
    n0 = wN;
    busStart();
    writeBurst(17'h00200, 1, 8'h77, "R5");
    sendPartial(8'hF0, 4, drv);
    busStop();
    checkBurst(n0, 17'h00200, 1, 8'h77, "R8");

    // R8: repeated START after three bits, then a fresh write
    n0 = wN;
    busStart();
    writeBurst(17'h00040, 0, 0, "R4");
    sendPartial(8'hA0, 3, drv);
    busRepStart();
    writeBurst(17'h00050, 1, 8'h99, "R8");
    busStop();
    checkBurst(n0, 17'h00050, 1, 8'h99, "R8");

    tick(10);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule